// File: doc/BRIEF.md
# Strip Hit Cluster Finder

The block takes one 128-strip binary hit frame from a silicon strip sensor. It finds every run of adjacent hit strips, which is a cluster, and reports each one as a centre position and a width. The strip data arrive on a 32-line port in four consecutive beats and are rebuilt into the full frame inside the block. The whole frame is then classified in a single clock by 32 small slice classifiers, each looking at four strips. A merger joins runs that cross slice boundaries, so each physical cluster comes out as exactly one record.

Results are presented as a fixed array of eight record slots, sorted by position, with a count and an overflow flag. The logic is meant for a 40 MHz frame clock. A new frame may start in the cycle right after the previous frame's last beat.

Top module: `strip_cluster_finder`

## Requirements
- R1: A frame is taken as four beats: the cycle with `frameStart` high is beat 0 and the next three cycles are beats 1, 2 and 3. Bit j of `beatData` in beat k is strip 32k+j. Input data outside a frame is ignored.
- R2: If beat 3 is on the inputs in cycle n, `outValid` is high in cycle n+2 and only there. `outValid` is never high in two consecutive cycles.
- R3: A run of adjacent hit strips gives exactly one cluster, whether or not it crosses a four-strip slice boundary or a beat boundary.
- R4: The centre of a cluster is its first strip index plus its last strip index, in half-strip units. The range is 0 to 254.
- R5: The width of a cluster is last − first + 1, saturated at 7.
- R6: `clusCount` gives the number of reported clusters. Slot i occupies bits [8i+7:8i] of `clusCentre` and bits [3i+2:3i] of `clusWidth`. Slots hold clusters in ascending position order, and slots at or above `clusCount` read zero.
- R7: If more than 8 clusters are found, `overflow` is high, `clusCount` is 8 and the 8 lowest clusters are reported. With 8 or fewer clusters, `overflow` is low.
- R8: Clusters touching strip 0 or strip 127 are reported with their normal centre and width.
- R9: A `frameStart` before beat 3 of a frame restarts assembly at beat 0. The partial frame gives no result.
- R10: Frames sent back to back, with a new `frameStart` in the cycle after beat 3, each give their own correct result.
- R11: While reset is active and after reset is released, `outValid`, `overflow`, `clusCount` and all slots are zero until the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Marks beat 0 of a frame |
| beatData | input | 32 | One quarter of the strip frame per beat |
| outValid | output | 1 | One-cycle pulse when a new result is presented |
| clusCount | output | 4 | Number of reported clusters (0..8) |
| overflow | output | 1 | More than 8 clusters were found |
| clusCentre | output | 64 | Eight 8-bit centres, slot 0 in the low bits |
| clusWidth | output | 24 | Eight 3-bit widths, slot 0 in the low bits |

## Verification
The bench goes after the following corner cases, each with the failure it would expose:
- Runs that straddle a slice edge (strips 3–4) and a beat edge (strips 30–33). A merger that ignored a boundary would split these into two records, raising the count and giving wrong centres.
- Runs touching strip 0 or strip 127, and the all-hit frame. A design that reached past the frame edge would drop or shift these.
- Exactly 8, 9 and 64 clusters, and runs of width 7 and 8. These catch an overflow flag that fires one cluster early, or a width that wraps instead of saturating.
- An aborted frame, and back-to-back frames. These catch a beat counter that fails to restart, or a result pulse that is lost or arrives a cycle off.

// File: rtl/scf_pkg.sv
package scf_pkg;
  // Strobes from the beat sequencer to the datapath.
  typedef struct packed {
    logic       loadEn;    // capture beatData into the frame this cycle
    logic       lastBeat;  // this capture completes the frame
    logic [7:0] beatIdx;   // which quarter of the frame is captured
  } scfStrobes_t;
endpackage

// File: rtl/scf_control.sv
module scf_control #(
  parameter int BEATS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameStart,
  output scf_pkg::scfStrobes_t strobes
);
  localparam int BIDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic              busy;
  logic [BIDX_W-1:0] beatCnt;
  logic [BIDX_W-1:0] nextIdx;

  always_comb begin
    strobes = '0;
    nextIdx = beatCnt + BIDX_W'(1);
    if (frameStart) begin
      strobes.loadEn  = 1'b1;
      strobes.beatIdx = '0;
    end else if (busy) begin
      strobes.loadEn  = 1'b1;
      strobes.beatIdx = 8'(nextIdx);
    end
    strobes.lastBeat = strobes.loadEn && (strobes.beatIdx == 8'(BEATS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      beatCnt <= '0;
    end else if (strobes.loadEn) begin
      beatCnt <= BIDX_W'(strobes.beatIdx);
      busy    <= !strobes.lastBeat;
    end else begin
      busy    <= 1'b0;
    end
  end

  generate
    if (BEATS > 1) begin : gSeqChk
      // R1: the closing beat is always preceded by the beat just before it
      a_r1_last_follows_prev: assert property (@(posedge clk) disable iff (!rstN)
        strobes.lastBeat |-> ($past(strobes.loadEn) && $past(strobes.beatIdx) == 8'(BEATS - 2)));
    end
  endgenerate
endmodule

// File: rtl/scf_datapath.sv
module scf_datapath #(
  parameter int NUM_STRIPS = 128,
  parameter int BUS_W      = 32,
  parameter int SLICE_W    = 4,
  parameter int MAX_CLUS   = 8,
  parameter int WIDTH_SAT  = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  scf_pkg::scfStrobes_t          strobes,
  input  logic [BUS_W-1:0]              beatData,
  output logic                          outValid,
  output logic [$clog2(MAX_CLUS+1)-1:0] clusCount,
  output logic                          overflow,
  output logic [MAX_CLUS*$clog2(2*NUM_STRIPS-1)-1:0] clusCentre,
  output logic [MAX_CLUS*$clog2(WIDTH_SAT+1)-1:0]    clusWidth
);
  localparam int BEATS      = NUM_STRIPS / BUS_W;
  localparam int NUM_SLICES = NUM_STRIPS / SLICE_W;
  localparam int POS_W      = $clog2(2*NUM_STRIPS-1);
  localparam int WID_W      = $clog2(WIDTH_SAT+1);
  localparam int CNT_W      = $clog2(MAX_CLUS+1);

  logic [NUM_STRIPS-1:0]   frameReg;
  logic                    evalReg;
  logic [NUM_STRIPS-1:0]   locStart, locEnd;   // per-slice classifier output
  logic [NUM_STRIPS-1:0]   mStart, mEnd;       // after boundary merge
  logic [NUM_SLICES-2:0]   link;               // run continues across boundary

  // Frame assembly from beats
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg <= '0;
      evalReg  <= 1'b0;
    end else begin
      for (int b = 0; b < BEATS; b++) begin
        if (strobes.loadEn && strobes.beatIdx == 8'(b))
          frameReg[b*BUS_W +: BUS_W] <= beatData;
      end
      evalReg <= strobes.lastBeat;
    end
  end

  // Slice classifiers and boundary merger
  generate
    for (genvar g = 0; g < NUM_SLICES; g++) begin : gSlice
      logic [SLICE_W-1:0] win, prevBits, nextBits, sStart, sEnd;
      assign win      = frameReg[g*SLICE_W +: SLICE_W];
      assign prevBits = {win[SLICE_W-2:0], 1'b0};
      assign nextBits = {1'b0, win[SLICE_W-1:1]};
      assign sStart   = win & ~prevBits;
      assign sEnd     = win & ~nextBits;
      assign locStart[g*SLICE_W +: SLICE_W] = sStart;
      assign locEnd[g*SLICE_W +: SLICE_W]   = sEnd;

      if (g < NUM_SLICES - 1) begin : gLink
        assign link[g] = win[SLICE_W-1] & frameReg[(g+1)*SLICE_W];
        assign mEnd[g*SLICE_W +: SLICE_W] =
          {sEnd[SLICE_W-1] & ~link[g], sEnd[SLICE_W-2:0]};
      end else begin : gLastEnd
        assign mEnd[g*SLICE_W +: SLICE_W] = sEnd;
      end

      if (g > 0) begin : gJoin
        assign mStart[g*SLICE_W +: SLICE_W] =
          {sStart[SLICE_W-1:1], sStart[0] & ~link[g-1]};
      end else begin : gFirstStart
        assign mStart[g*SLICE_W +: SLICE_W] = sStart;
      end
    end
  endgenerate

  // Ordered extraction of up to MAX_CLUS records
  logic [POS_W-1:0] cenN [MAX_CLUS];
  logic [WID_W-1:0] widN [MAX_CLUS];
  logic [CNT_W-1:0] countN;
  logic             ovfN;

  always_comb begin
    int found;
    logic [POS_W-1:0] curStart;
    logic [POS_W-1:0] runLen;
    found    = 0;
    curStart = '0;
    runLen   = '0;
    for (int i = 0; i < MAX_CLUS; i++) begin
      cenN[i] = '0;
      widN[i] = '0;
    end
    for (int s = 0; s < NUM_STRIPS; s++) begin
      if (mStart[s]) curStart = POS_W'(s);
      if (mEnd[s]) begin
        runLen = POS_W'(s) - curStart + POS_W'(1);
        for (int i = 0; i < MAX_CLUS; i++) begin
          if (found == i) begin
            cenN[i] = curStart + POS_W'(s);
            widN[i] = (runLen > POS_W'(WIDTH_SAT)) ? WID_W'(WIDTH_SAT) : runLen[WID_W-1:0];
          end
        end
        found = found + 1;
      end
    end
    ovfN   = (found > MAX_CLUS);
    countN = ovfN ? CNT_W'(MAX_CLUS) : CNT_W'(found);
  end

  // Result registers
  logic [POS_W-1:0] cenQ [MAX_CLUS];
  logic [WID_W-1:0] widQ [MAX_CLUS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      clusCount <= '0;
      overflow  <= 1'b0;
      for (int i = 0; i < MAX_CLUS; i++) begin
        cenQ[i] <= '0;
        widQ[i] <= '0;
      end
    end else begin
      outValid <= evalReg;
      if (evalReg) begin
        clusCount <= countN;
        overflow  <= ovfN;
        for (int i = 0; i < MAX_CLUS; i++) begin
          cenQ[i] <= cenN[i];
          widQ[i] <= widN[i];
        end
      end
    end
  end

  generate
    for (genvar i = 0; i < MAX_CLUS; i++) begin : gOut
      assign clusCentre[i*POS_W +: POS_W] = cenQ[i];
      assign clusWidth[i*WID_W +: WID_W]  = widQ[i];

      // R5: a reported width is never zero and never beyond the cap
      a_r5_width_range: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && CNT_W'(i) < clusCount) |-> (widQ[i] != '0 && widQ[i] <= WID_W'(WIDTH_SAT)));
      // R4: an odd width puts the centre on a strip, an even width between strips
      a_r4_centre_parity: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && CNT_W'(i) < clusCount && widQ[i] < WID_W'(WIDTH_SAT)) |-> (cenQ[i][0] != widQ[i][0]));
      // R6: empty slots read zero
      a_r6_empty_slot: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && CNT_W'(i) >= clusCount) |-> (cenQ[i] == '0 && widQ[i] == '0));
      if (i < MAX_CLUS - 1) begin : gOrd
        // R6: records ascend in position
        a_r6_ascending: assert property (@(posedge clk) disable iff (!rstN)
          (outValid && CNT_W'(i+1) < clusCount) |-> (cenQ[i+1] > cenQ[i]));
      end
    end
  endgenerate

  // R2: the result strobe lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  // R7: overflow only with every slot in use
  a_r7_overflow_full: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (clusCount == CNT_W'(MAX_CLUS)));
endmodule

// File: rtl/strip_cluster_finder.sv
module strip_cluster_finder #(
  parameter int NUM_STRIPS = 128,
  parameter int BUS_W      = 32,
  parameter int SLICE_W    = 4,
  parameter int MAX_CLUS   = 8,
  parameter int WIDTH_SAT  = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          frameStart,
  input  logic [BUS_W-1:0]              beatData,
  output logic                          outValid,
  output logic [$clog2(MAX_CLUS+1)-1:0] clusCount,
  output logic                          overflow,
  output logic [MAX_CLUS*$clog2(2*NUM_STRIPS-1)-1:0] clusCentre,
  output logic [MAX_CLUS*$clog2(WIDTH_SAT+1)-1:0]    clusWidth
);
  localparam int BEATS = NUM_STRIPS / BUS_W;

  scf_pkg::scfStrobes_t strobes;

  scf_control #(.BEATS(BEATS)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .strobes   (strobes)
  );

  scf_datapath #(
    .NUM_STRIPS(NUM_STRIPS),
    .BUS_W     (BUS_W),
    .SLICE_W   (SLICE_W),
    .MAX_CLUS  (MAX_CLUS),
    .WIDTH_SAT (WIDTH_SAT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .beatData  (beatData),
    .outValid  (outValid),
    .clusCount (clusCount),
    .overflow  (overflow),
    .clusCentre(clusCentre),
    .clusWidth (clusWidth)
  );
endmodule

// File: tb/strip_cluster_finder_tb_top.sv
module strip_cluster_finder_tb_top;
  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic [31:0] beatData = '0;
  logic        outValid;
  logic [3:0]  clusCount;
  logic        overflow;
  logic [63:0] clusCentre;
  logic [23:0] clusWidth;

  strip_cluster_finder dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .beatData(beatData),
    .outValid(outValid), .clusCount(clusCount), .overflow(overflow),
    .clusCentre(clusCentre), .clusWidth(clusWidth)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    nChecks = 0;
  int    nBad = 0;
  bit    done = 0;
  string scen = "R11 reset";

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, scen, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  bit [127:0] mFrame;
  int  mBeat;
  bit  mBusy, pend, expValid, expOvf;
  int  expCnt;
  int  expCen [8];
  int  expWid [8];

  function automatic void refEval();
    int s, n, st;
    s = 0; n = 0;
    for (int i = 0; i < 8; i++) begin expCen[i] = 0; expWid[i] = 0; end
    while (s < 128) begin
      if (mFrame[s]) begin
        st = s;
        while (s < 128 && mFrame[s]) s++;
        if (n < 8) begin
          expCen[n] = st + s - 1;
          expWid[n] = (s - st > 7) ? 7 : s - st;
        end
        n++;
      end else s++;
    end
    expOvf = (n > 8);
    expCnt = expOvf ? 8 : n;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; pend = 0; expValid = 0; mBeat = 0;
    end else begin
      expValid = pend;
      if (pend) refEval();
      pend = 0;
      if (frameStart) begin
        mBeat = 0; mBusy = 1; mFrame[31:0] = beatData;
      end else if (mBusy) begin
        mBeat++; mFrame[mBeat*32 +: 32] = beatData;
      end
      if (mBusy && mBeat == 3) begin mBusy = 0; pend = 1; end
    end
  end

  // Compare on every falling edge once out of reset
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 valid timing", int'(outValid), int'(expValid));
      if (expValid && outValid) begin
        chk("R6 count", int'(clusCount), expCnt);
        chk("R7 overflow", int'(overflow), int'(expOvf));
        for (int i = 0; i < 8; i++) begin
          chk("R4 centre", int'(clusCentre[i*8 +: 8]), expCen[i]);
          chk("R5 width", int'(clusWidth[i*3 +: 3]), expWid[i]);
        end
      end
    end
  end

  task automatic sendFrame(input logic [127:0] f);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      frameStart = (b == 0);
      beatData   = f[b*32 +: 32];
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frameStart = 1'b0;
      beatData   = $urandom;   // R1: junk outside a frame must be ignored
    end
  endtask

  function automatic logic [127:0] runBits(input int lo, input int hi);
    logic [127:0] v;
    v = '0;
    for (int s = lo; s <= hi; s++) v[s] = 1'b1;
    return v;
  endfunction

  function automatic logic [127:0] evenSingles(input int n);
    logic [127:0] v;
    v = '0;
    for (int k = 0; k < n; k++) v[2*k] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 valid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 count after reset", int'(clusCount), 0);
    chk("R11 overflow after reset", int'(overflow), 0);
    chk("R11 centres after reset", int'(clusCentre != '0), 0);
    chk("R11 widths after reset", int'(clusWidth != '0), 0);
    idle(2);

    scen = "R1 empty frame";        sendFrame('0); idle(3);
    scen = "R1 one hit per beat";   sendFrame(runBits(5,5) | runBits(40,41) | runBits(77,77) | runBits(100,102)); idle(3);
    scen = "R8 strip 0";            sendFrame(runBits(0,1)); idle(3);
    scen = "R8 strip 127";          sendFrame(runBits(125,127)); idle(3);
    scen = "R8 all strips hit";     sendFrame('1); idle(3);
    scen = "R3 slice edge 3-4";     sendFrame(runBits(3,4)); idle(3);
    scen = "R3 beat edge 30-33";    sendFrame(runBits(30,33)); idle(3);
    scen = "R5 width 7 and 8";      sendFrame(runBits(60,66) | runBits(70,77)); idle(3);
    scen = "R5 long run 10-40";     sendFrame(runBits(10,40)); idle(3);
    scen = "R7 exactly 8";          sendFrame(evenSingles(8)); idle(3);
    scen = "R7 nine clusters";      sendFrame(evenSingles(9)); idle(3);
    scen = "R7 alternating";        sendFrame({32{4'b0101}}); idle(3);

    scen = "R9 restart mid-frame";
    @(negedge clk); frameStart = 1'b1; beatData = 32'hFFFF_0000;
    @(negedge clk); frameStart = 1'b0; beatData = 32'h0F0F_0F0F;
    sendFrame(runBits(50,52) | runBits(90,90));
    idle(3);

    scen = "R10 back to back";
    sendFrame(runBits(7,9));
    sendFrame(runBits(31,32) | runBits(127,127));
    sendFrame(evenSingles(12));
    idle(3);

    scen = "R6 random frames";
    for (int r = 0; r < 40; r++) begin
      logic [127:0] f;
      f = {$urandom, $urandom, $urandom, $urandom};
      if (r % 3 == 0) f = f & {$urandom, $urandom, $urandom, $urandom};
      if (r % 3 == 1) f = f | {$urandom, $urandom, $urandom, $urandom};
      sendFrame(f);
      if (r % 4 != 0) idle(r % 5);
    end
    idle(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      nChecks++; nBad++;
      $display("FAIL watchdog [%s] actual=timeout expected=finish", scen);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule